// File: doc/BRIEF.md
# Cluster Private Window Decoder

This block sits at the entrance to a processor cluster's 8 KiB private peripheral window. Each access on a simple register bus carries an address, a read or write strobe, write data and the ID of the requesting core. The block steers that access to one of two places. The first is a small snoop-control register file built into the block. The second is one of the external per-core or shared peripherals: interrupt CPU interfaces, timers, watchdogs, and the interrupt distributor.

For every external target the block drives a select line and a window-local offset while the strobe is high. The target's read data is captured and returned on the bus one clock after the strobe. Each per-core peripheral also has an alias window at the start of its range, and the requester ID decides which core's instance the alias reaches. Accesses that match no window are flagged with a one-cycle error pulse, as are accesses to unused register offsets and to slots above the configured core count. The core count is a parameter from 1 to 4.

Top module: `prv_window_dec`

## Requirements
- R1: The control register at offset 0x000 resets to zero. A write stores only bit 0 of the write data, and a read returns that bit with bits 31:1 zero.
- R2: A read at offset 0x004 returns `((1<<NCPU)-1)<<4 | (NCPU-1)`. A write at 0x004 or 0x008 changes nothing and pulses the error output.
- R3: Offsets 0x008 and 0x00C read zero. A write to 0x00C leaves the control register unchanged. None of these raises an error.
- R4: Any other offset in 0x000–0x0FF reads zero, discards writes (the control register keeps its value) and pulses the error output.
- R5: The interface window at 0x200 + i·0x100 selects core i's interface (bit i of `cif_sel`), with `cif_off` equal to address bits 7:0.
- R6: The alias windows route to the instance of the core given by `bus_cpu_id`. These are the interface alias at 0x100–0x1FF, the timer alias at 0x600–0x61F and the watchdog alias at 0x620–0x63F.
- R7: In slot page 0x600 + k·0x100 (k = 1..NCPU, core k−1), bytes 0x00–0x1F select the timer and bytes 0x20–0x3F select the watchdog. The 5-bit offset is address bits 4:0. Bytes 0x40–0xFF of the page are undefined.
- R8: Offsets 0x1000–0x1FFF select the distributor, with a 12-bit offset equal to address bits 11:0.
- R9: An access to an undefined window, to a slot for a core at or above NCPU, or to an alias while `bus_cpu_id` ≥ NCPU drives no select. Such a read returns zero, and the access pulses `bus_derr`.
- R10: `bus_rdata` carries the read result in the single cycle after a read strobe and is zero otherwise. `bus_derr` is high for exactly the single cycle after a faulty strobe.
- R11: At most one select line is high at any time, and none is high without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 13 | Byte offset into the private window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DW | Write data |
| bus_cpu_id | input | 2 | ID of the requesting core |
| bus_rdata | output | DW | Read data, valid the cycle after bus_rd |
| bus_derr | output | 1 | Decode-error pulse, the cycle after the strobe |
| tgt_wr | output | 1 | Write strobe forwarded to targets |
| tgt_wdata | output | DW | Write data forwarded to targets |
| cif_sel | output | NCPU | Interrupt CPU-interface selects, one per core |
| cif_off | output | 8 | Offset inside the interface window |
| cif_rdata | input | NCPU·DW | Interface read data, core i in slice i |
| tmr_sel | output | NCPU | Timer selects, one per core |
| wdg_sel | output | NCPU | Watchdog selects, one per core |
| tw_off | output | 5 | Offset inside a timer or watchdog window |
| tmr_rdata | input | NCPU·DW | Timer read data, core i in slice i |
| wdg_rdata | input | NCPU·DW | Watchdog read data, core i in slice i |
| dist_sel | output | 1 | Distributor select |
| dist_off | output | 12 | Offset inside the distributor window |
| dist_rdata | input | DW | Distributor read data |

## Verification
The hardest cases to reach are the ones where the same address means different things depending on the requester. Examples are an alias hit from a core ID that is out of range, and a slot page that lies just past the configured core count. The bench instantiates two cores so that pages 0x400, 0x500 and 0x900 exist in the address space but name no target. It then issues alias accesses with every ID, including one at or above the count. Each external target is modelled by read data that encodes its kind, core and offset, so one returned word shows whether both the steering and the offset were right.

// File: rtl/prv_pkg.sv
package prv_pkg;
   localparam int ADDR_W = 13;
   localparam int ID_W   = 2;
   localparam int MAX_CPU = 4;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_SCU,
      TGT_CIF,
      TGT_TMR,
      TGT_WDG,
      TGT_DIST
   } tgt_e;

   typedef struct packed {
      tgt_e             tgt;
      logic [ID_W-1:0]  cpu;
      logic [11:0]      off;
      logic             err;
   } dec_t;
endpackage

// File: rtl/prv_addr_decode.sv
module prv_addr_decode
   import prv_pkg::*;
#(
   parameter int NCPU = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ID_W-1:0]   cpu_id,
   output dec_t              dec
);
   localparam logic [3:0] CIF_LAST  = 4'(NCPU + 1);
   localparam logic [3:0] TW_FIRST  = 4'd6;
   localparam logic [3:0] TW_LAST   = 4'(6 + NCPU);
   localparam logic [2:0] NCPU_W    = 3'(NCPU);

   logic [3:0] page;
   logic [3:0] slot;
   logic       per_cpu;

   assign page = addr[11:8];

   always_comb begin
      dec.tgt = TGT_NONE;
      dec.cpu = '0;
      dec.off = {4'b0, addr[7:0]};
      dec.err = 1'b0;
      slot    = '0;
      per_cpu = 1'b0;
      if (addr[12]) begin
         dec.tgt = TGT_DIST;
         dec.off = addr[11:0];
      end else if (page == 4'd0) begin
         dec.tgt = TGT_SCU;
      end else if (page <= CIF_LAST) begin
         dec.tgt = TGT_CIF;
         slot    = page - 4'd1;
         per_cpu = 1'b1;
      end else if (page >= TW_FIRST && page <= TW_LAST) begin
         slot    = page - TW_FIRST;
         per_cpu = 1'b1;
         dec.off = {7'b0, addr[4:0]};
         if (addr[7:5] == 3'd0)      dec.tgt = TGT_TMR;
         else if (addr[7:5] == 3'd1) dec.tgt = TGT_WDG;
         else                        dec.err = 1'b1;
      end else begin
         dec.err = 1'b1;
      end

      if (per_cpu) begin
         if (slot == 4'd0) begin
            if ({1'b0, cpu_id} < NCPU_W) dec.cpu = cpu_id;
            else                         dec.err = 1'b1;
         end else begin
            dec.cpu = 2'(slot - 4'd1);
         end
      end

      if (dec.err) dec.tgt = TGT_NONE;
   end
endmodule

// File: rtl/prv_scu_regs.sv
module prv_scu_regs #(
   parameter int NCPU = 4,
   parameter int DW   = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          wr,
   input  logic [7:0]    off,
   input  logic          wbit,
   output logic [DW-1:0] rdata,
   output logic          bad
);
   localparam logic [DW-1:0] CFG_VAL =
      DW'((((1 << NCPU) - 1) << 4) | (NCPU - 1));

   logic ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                          ctrl_q <= 1'b0;
      else if (sel && wr && off == 8'h00)  ctrl_q <= wbit;
   end

   always_comb begin
      rdata = '0;
      bad   = 1'b0;
      case (off)
         8'h00: rdata = {{(DW-1){1'b0}}, ctrl_q};
         8'h04: begin rdata = CFG_VAL; bad = wr; end
         8'h08: bad = wr;
         8'h0C: ;
         default: bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/prv_resp_reg.sv
module prv_resp_reg #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd,
   input  logic          fault,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] rdata,
   output logic          derr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         derr  <= 1'b0;
      end else begin
         rdata <= (rd && !fault) ? din : '0;
         derr  <= fault;
      end
   end
endmodule

// File: rtl/prv_window_dec.sv
module prv_window_dec
   import prv_pkg::*;
#(
   parameter int NCPU = 4,
   parameter int DW   = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_rd,
   input  logic                 bus_wr,
   input  logic [DW-1:0]        bus_wdata,
   input  logic [ID_W-1:0]      bus_cpu_id,
   output logic [DW-1:0]        bus_rdata,
   output logic                 bus_derr,
   output logic                 tgt_wr,
   output logic [DW-1:0]        tgt_wdata,
   output logic [NCPU-1:0]      cif_sel,
   output logic [7:0]           cif_off,
   input  logic [NCPU*DW-1:0]   cif_rdata,
   output logic [NCPU-1:0]      tmr_sel,
   output logic [NCPU-1:0]      wdg_sel,
   output logic [4:0]           tw_off,
   input  logic [NCPU*DW-1:0]   tmr_rdata,
   input  logic [NCPU*DW-1:0]   wdg_rdata,
   output logic                 dist_sel,
   output logic [11:0]          dist_off,
   input  logic [DW-1:0]        dist_rdata
);
   generate
      if (NCPU < 1 || NCPU > MAX_CPU) begin : g_bad_ncpu
         $error("prv_window_dec: NCPU must be 1..4");
      end
      if (DW < 8) begin : g_bad_dw
         $error("prv_window_dec: DW must be at least 8");
      end
   endgenerate

   dec_t          dec;
   logic          access;
   logic          scu_sel;
   logic          scu_bad;
   logic          fault;
   logic [DW-1:0] scu_rdata;
   logic [DW-1:0] mux_rdata;

   assign access = bus_rd | bus_wr;

   prv_addr_decode #(.NCPU(NCPU)) u_decode (
      .addr   (bus_addr),
      .cpu_id (bus_cpu_id),
      .dec    (dec)
   );

   assign scu_sel = access && dec.tgt == TGT_SCU;

   prv_scu_regs #(.NCPU(NCPU), .DW(DW)) u_scu (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (scu_sel),
      .wr    (bus_wr),
      .off   (dec.off[7:0]),
      .wbit  (bus_wdata[0]),
      .rdata (scu_rdata),
      .bad   (scu_bad)
   );

   assign fault = access && (dec.err || (scu_sel && scu_bad));

   genvar gi;
   generate
      for (gi = 0; gi < NCPU; gi++) begin : g_sel
         assign cif_sel[gi] = access && dec.tgt == TGT_CIF && dec.cpu == ID_W'(gi);
         assign tmr_sel[gi] = access && dec.tgt == TGT_TMR && dec.cpu == ID_W'(gi);
         assign wdg_sel[gi] = access && dec.tgt == TGT_WDG && dec.cpu == ID_W'(gi);
      end
   endgenerate

   assign dist_sel  = access && dec.tgt == TGT_DIST;
   assign cif_off   = dec.off[7:0];
   assign tw_off    = dec.off[4:0];
   assign dist_off  = dec.off;
   assign tgt_wr    = bus_wr;
   assign tgt_wdata = bus_wdata;

   always_comb begin
      mux_rdata = '0;
      case (dec.tgt)
         TGT_SCU:  mux_rdata = scu_rdata;
         TGT_DIST: mux_rdata = dist_rdata;
         TGT_CIF, TGT_TMR, TGT_WDG: begin
            for (int i = 0; i < NCPU; i++) begin
               if (dec.cpu == ID_W'(i)) begin
                  if (dec.tgt == TGT_CIF)      mux_rdata = cif_rdata[i*DW +: DW];
                  else if (dec.tgt == TGT_TMR) mux_rdata = tmr_rdata[i*DW +: DW];
                  else                         mux_rdata = wdg_rdata[i*DW +: DW];
               end
            end
         end
         default: mux_rdata = '0;
      endcase
   end

   prv_resp_reg #(.DW(DW)) u_resp (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (bus_rd),
      .fault (fault),
      .din   (mux_rdata),
      .rdata (bus_rdata),
      .derr  (bus_derr)
   );
endmodule

// File: rtl/prv_window_chk.sv
module prv_window_chk
   import prv_pkg::*;
#(
   parameter int NCPU = 4,
   parameter int DW   = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_rd,
   input logic                bus_wr,
   input logic [ID_W-1:0]     bus_cpu_id,
   input logic [DW-1:0]       bus_rdata,
   input logic                bus_derr,
   input logic [NCPU-1:0]     cif_sel,
   input logic [NCPU-1:0]     tmr_sel,
   input logic [NCPU-1:0]     wdg_sel,
   input logic                dist_sel
);
   localparam logic [DW-1:0] CFG_EXP =
      DW'((((1 << NCPU) - 1) << 4) | (NCPU - 1));

   logic [3*NCPU:0] all_sel;
   logic            strobe;
   logic            alias_ok;

   assign all_sel  = {cif_sel, tmr_sel, wdg_sel, dist_sel};
   assign strobe   = bus_rd | bus_wr;
   assign alias_ok = strobe && bus_addr[12:8] == 5'd1 && {1'b0, bus_cpu_id} < 3'(NCPU);

   // R11
   one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(all_sel));

   // R11
   idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |-> all_sel == '0);

   // R10
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0);

   // R9
   derr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> !bus_derr);

   // R1
   ctrl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 13'h000) |=> bus_rdata[DW-1:1] == '0);

   // R2
   cfg_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 13'h004) |=> bus_rdata == CFG_EXP);

   // R6
   alias_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alias_ok |-> cif_sel[bus_cpu_id]);

   // R9
   err_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && all_sel == '0 && bus_addr[12:8] != 5'd0) |=> bus_derr);
endmodule

bind prv_window_dec prv_window_chk #(.NCPU(NCPU), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_rd     (bus_rd),
   .bus_wr     (bus_wr),
   .bus_cpu_id (bus_cpu_id),
   .bus_rdata  (bus_rdata),
   .bus_derr   (bus_derr),
   .cif_sel    (cif_sel),
   .tmr_sel    (tmr_sel),
   .wdg_sel    (wdg_sel),
   .dist_sel   (dist_sel)
);

// File: tb/test_prv_window_dec.sv
`timescale 1ns/1ps
module test_prv_window_dec;
   localparam int NCPU = 2;
   localparam int DW   = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [12:0]     bus_addr = '0;
   logic            bus_rd = 1'b0;
   logic            bus_wr = 1'b0;
   logic [DW-1:0]   bus_wdata = '0;
   logic [1:0]      bus_cpu_id = '0;
   logic [DW-1:0]   bus_rdata;
   logic            bus_derr;
   logic            tgt_wr;
   logic [DW-1:0]   tgt_wdata;
   logic [NCPU-1:0] cif_sel, tmr_sel, wdg_sel;
   logic [7:0]      cif_off;
   logic [4:0]      tw_off;
   logic [11:0]     dist_off;
   logic            dist_sel;
   logic [NCPU*DW-1:0] cif_rdata, tmr_rdata, wdg_rdata;
   logic [DW-1:0]   dist_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   // target models: kind tag, core index and offset encoded in each word
   always_comb begin
      for (int i = 0; i < NCPU; i++) begin
         cif_rdata[i*DW +: DW] = 32'hC1000000 | (i << 16) | 32'(cif_off);
         tmr_rdata[i*DW +: DW] = 32'h7A000000 | (i << 16) | 32'(tw_off);
         wdg_rdata[i*DW +: DW] = 32'h3D000000 | (i << 16) | 32'(tw_off);
      end
      dist_rdata = 32'hD1500000 | 32'(dist_off);
   end

   prv_window_dec #(.NCPU(NCPU), .DW(DW)) i_prv_window_dec (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_cpu_id(bus_cpu_id),
      .bus_rdata(bus_rdata), .bus_derr(bus_derr), .tgt_wr(tgt_wr),
      .tgt_wdata(tgt_wdata), .cif_sel(cif_sel), .cif_off(cif_off),
      .cif_rdata(cif_rdata), .tmr_sel(tmr_sel), .wdg_sel(wdg_sel),
      .tw_off(tw_off), .tmr_rdata(tmr_rdata), .wdg_rdata(wdg_rdata),
      .dist_sel(dist_sel), .dist_off(dist_off), .dist_rdata(dist_rdata)
   );

   // snapshot taken during the strobe cycle and after it
   logic [NCPU-1:0] s_cif, s_tmr, s_wdg;
   logic            s_dist;
   logic [7:0]      s_cof;
   logic [4:0]      s_tof;
   logic [11:0]     s_dof;
   logic [DW-1:0]   r_data;
   logic            r_err;

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input bit rd, input bit wr, input logic [12:0] a,
                      input logic [1:0] id, input logic [DW-1:0] wd);
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_addr = a; bus_cpu_id = id; bus_wdata = wd;
      #1;
      s_cif = cif_sel; s_tmr = tmr_sel; s_wdg = wdg_sel; s_dist = dist_sel;
      s_cof = cif_off; s_tof = tw_off; s_dof = dist_off;
      @(negedge clk);
      bus_rd = 0; bus_wr = 0;
      r_data = bus_rdata; r_err = bus_derr;
   endtask

   function automatic logic [DW-1:0] sel_word();
      return {20'b0, s_dist, 1'b0, s_wdg, 2'b0, s_tmr, 2'b0, s_cif};
   endfunction

   task automatic t_reset();
      chk("R10 reset rdata", bus_rdata, 0);
      chk("R10 reset derr", 32'(bus_derr), 0);
      acc(1, 0, 13'h000, 0, 0);
      chk("R1 ctrl after reset", r_data, 0);
   endtask

   task automatic t_ctrl();
      acc(0, 1, 13'h000, 0, 32'hFFFF_FFFF);
      chk("R1 write derr", 32'(r_err), 0);
      acc(1, 0, 13'h000, 0, 0);
      chk("R1 ctrl bit0 only", r_data, 1);
      acc(0, 1, 13'h000, 0, 32'hFFFF_FFFE);
      acc(1, 0, 13'h000, 0, 0);
      chk("R1 ctrl cleared", r_data, 0);
   endtask

   task automatic t_cfg();
      acc(1, 0, 13'h004, 0, 0);
      chk("R2 config value", r_data, 32'h31);
      acc(0, 1, 13'h004, 0, 32'hFF);
      chk("R2 config write error", 32'(r_err), 1);
      acc(1, 0, 13'h004, 0, 0);
      chk("R2 config unchanged", r_data, 32'h31);
      acc(0, 1, 13'h008, 0, 32'h1);
      chk("R2 status write error", 32'(r_err), 1);
   endtask

   task automatic t_misc();
      acc(0, 1, 13'h000, 0, 1);
      acc(0, 1, 13'h00C, 0, 32'hFFFF_FFFE);
      chk("R3 invalidate no error", 32'(r_err), 0);
      acc(1, 0, 13'h000, 0, 0);
      chk("R3 ctrl kept after invalidate", r_data, 1);
      acc(1, 0, 13'h00C, 0, 0);
      chk("R3 invalidate reads zero", r_data, 0);
      chk("R3 invalidate read no error", 32'(r_err), 0);
      acc(1, 0, 13'h008, 0, 0);
      chk("R3 status reads zero", r_data, 0);
   endtask

   task automatic t_bad_scu();
      acc(1, 0, 13'h010, 0, 0);
      chk("R4 bad read data", r_data, 0);
      chk("R4 bad read error", 32'(r_err), 1);
      acc(0, 1, 13'h040, 0, 0);
      chk("R4 bad write error", 32'(r_err), 1);
      acc(0, 1, 13'h001, 0, 0);
      acc(1, 0, 13'h000, 0, 0);
      chk("R4 ctrl kept after bad write", r_data, 1);
   endtask

   task automatic t_cif();
      acc(1, 0, 13'h234, 1, 0);
      chk("R5 cpu0 select", sel_word(), 32'h1);
      chk("R5 cpu0 offset", 32'(s_cof), 32'h34);
      chk("R5 cpu0 data", r_data, 32'hC1000034);
      acc(1, 0, 13'h3F0, 0, 0);
      chk("R5 cpu1 select", sel_word(), 32'h2);
      chk("R5 cpu1 data", r_data, 32'hC10100F0);
   endtask

   task automatic t_alias();
      acc(1, 0, 13'h108, 1, 0);
      chk("R6 iface alias id1", sel_word(), 32'h2);
      chk("R6 iface alias data", r_data, 32'hC1010008);
      acc(1, 0, 13'h108, 0, 0);
      chk("R6 iface alias id0", r_data, 32'hC1000008);
      acc(1, 0, 13'h604, 0, 0);
      chk("R6 timer alias id0", r_data, 32'h7A000004);
      acc(1, 0, 13'h628, 1, 0);
      chk("R6 wdog alias id1 sel", sel_word(), 32'h200);
      chk("R6 wdog alias id1", r_data, 32'h3D010008);
   endtask

   task automatic t_tw();
      acc(1, 0, 13'h710, 1, 0);
      chk("R7 timer cpu0 sel", sel_word(), 32'h10);
      chk("R7 timer cpu0 off", 32'(s_tof), 32'h10);
      chk("R7 timer cpu0 data", r_data, 32'h7A000010);
      acc(1, 0, 13'h83C, 0, 0);
      chk("R7 wdog cpu1 data", r_data, 32'h3D01001C);
      acc(1, 0, 13'h740, 0, 0);
      chk("R7 gap in slot error", 32'(r_err), 1);
      chk("R7 gap in slot sel", sel_word(), 0);
   endtask

   task automatic t_dist();
      acc(1, 0, 13'h1ABC, 3, 0);
      chk("R8 dist sel", sel_word(), 32'h800);
      chk("R8 dist off", 32'(s_dof), 32'hABC);
      chk("R8 dist data", r_data, 32'hD1500ABC);
      chk("R8 dist no error", 32'(r_err), 0);
   endtask

   task automatic t_err();
      acc(1, 0, 13'h400, 0, 0);
      chk("R9 iface slot over count sel", sel_word(), 0);
      chk("R9 iface slot over count err", 32'(r_err), 1);
      chk("R9 iface slot over count data", r_data, 0);
      acc(1, 0, 13'h900, 0, 0);
      chk("R9 timer slot over count err", 32'(r_err), 1);
      acc(1, 0, 13'h500, 0, 0);
      chk("R9 unmapped page err", 32'(r_err), 1);
      acc(1, 0, 13'h104, 2, 0);
      chk("R9 alias bad id sel", sel_word(), 0);
      chk("R9 alias bad id err", 32'(r_err), 1);
      chk("R9 alias bad id data", r_data, 0);
   endtask

   task automatic t_timing();
      acc(1, 0, 13'h200, 0, 0);
      chk("R10 data one cycle after", r_data, 32'hC1000000);
      @(negedge clk);
      chk("R10 data cleared next", bus_rdata, 0);
      acc(0, 1, 13'h050, 0, 0);
      chk("R10 derr one cycle after", 32'(r_err), 1);
      @(negedge clk);
      chk("R10 derr single cycle", 32'(bus_derr), 0);
      chk("R11 no select idle", {20'b0, dist_sel, 1'b0, wdg_sel, 2'b0, tmr_sel, 2'b0, cif_sel}, 0);
      acc(0, 1, 13'h300, 1, 32'hA5A5_0001);
      chk("R11 write select one", sel_word(), 32'h2);
      chk("R11 write data no readback", r_data, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl();
      t_cfg();
      t_misc();
      t_bad_scu();
      t_cif();
      t_alias();
      t_tw();
      t_dist();
      t_err();
      t_timing();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule